// File: doc/BRIEF.md
# Dual-Output Serial Flash Stream Reader

This block is the host side of a serial flash read channel that uses the dual-output fast read. A client hands it a start address and a byte count. The block lowers chip select and clocks the read command, the address and a dummy byte out on the bidirectional data line. It then releases that line and rebuilds bytes from two data lines, taking two bits per serial clock. Each recovered byte goes out on a valid/ready port together with the array address it was read from.

The serial clock is derived from the system clock by a fixed half-period divider. Reads run continuously, and the reported address wraps from the top of the array back to zero with no pause. If the byte consumer stalls, the serial clock is parked low at a byte boundary, so no data is lost. When the requested count has been received, chip select is raised, the clock parks low, a one-cycle completion pulse is given and the engine returns to idle.

Top module: `dual_flash_reader`

## Requirements
- R1: After chip select goes low, the command byte 3Bh is sent on `sio_out`, most significant bit first, one bit per serial clock. `sio_out` only changes on a falling edge of `sck`.
- R2: The 24-bit request address follows the command as three bytes, most significant bit first, on the same line.
- R3: Eight dummy clocks follow the address. `sio_oe` stays high for the first 32 clocks and is low from the 33rd rising edge (the first dummy clock) to the end of the transaction.
- R4: After 40 clocks, each rising edge of `sck` samples two bits: `so_in` supplies the higher-order bit and `sio_in` the next lower one. The first clock of a byte gives bits 7:6 and the fourth gives bits 1:0.
- R5: Each rebuilt byte is offered on `out_data` with `out_addr` equal to its array address. Addresses rise by one per byte, starting at the request address, and exactly `req_count` bytes are delivered.
- R6: Addresses are taken modulo 2^ARRAY_BITS (default 21 bits). The byte after address 1FFFFFh is reported at 000000h, with no extra serial clocks.
- R7: A transaction with count N has exactly 40 + 4*N rising edges of `sck`. While `out_ready` stays high, consecutive rising edges are exactly 2*HALF_DIV system clocks apart.
- R8: A byte on the output holds its data and address while `out_valid` is high and `out_ready` is low. If the consumer stalls, `sck` stops low before the next byte starts and resumes once the byte is taken, so no byte is lost or overwritten.
- R9: After the last byte, `cs_n` rises while `sck` is low, `done` pulses high for one cycle with `cs_n` high, and `req_ready` returns high within CS_GAP+1 cycles.
- R10: Between two transactions, `cs_n` stays high for at least two system clock cycles.
- R11: During and after reset: `cs_n` is high, `sck` is low, `sio_oe` is low, `out_valid` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start request |
| req_ready | output | 1 | Engine idle, request accepted when both high |
| req_addr | input | 24 | First array address to read |
| req_count | input | CNT_W | Number of bytes to read (nonzero) |
| done | output | 1 | One-cycle pulse when a transaction closes |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| sio_out | output | 1 | Command, address and dummy bits toward the flash |
| sio_oe | output | 1 | Output enable of the bidirectional line |
| sio_in | input | 1 | Bidirectional line as seen from the host, lower data bit |
| so_in | input | 1 | Flash primary output, higher data bit |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Rebuilt byte |
| out_addr | output | 24 | Array address of the byte |

## Verification
The checker assumes that `req_count` is never zero. It also assumes the flash side changes `so_in` and `sio_in` only on falling edges of `sck`, so they are stable at every sampling rising edge. The stimulus uses counts from 1 to 12 only. The flash model updates its outputs on the negative edge of `sck` and drives `sio_in` only while `sio_oe` is low. Consumer readiness is drawn from three random patterns: always ready, mostly ready, and rarely ready. Directed cases cover a single byte, a read across the array top, and a transaction started right after the previous one.

// File: rtl/dfr_pkg.sv
package dfr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_GAP  = 2'd3
  } dfr_state_e;

  localparam logic [7:0] DUAL_READ_OP = 8'h3B;
  localparam int ADDR_W       = 24;
  localparam int HDR_BITS     = 8 + ADDR_W + 8;
  localparam int DUMMY_FIRST  = 8 + ADDR_W;
  localparam int PAIRS_PER_B  = 4;

endpackage

// File: rtl/dfr_sck_gen.sv
module dfr_sck_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic sck,
  output logic rise_ev,
  output logic fall_ev
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sck_q, sck_d;
  logic          tick;

  assign tick    = run && (cnt_q == LAST);
  assign rise_ev = tick && !sck_q && !hold;
  assign fall_ev = tick && sck_q;

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else begin
      if (cnt_q == LAST) begin
        // park the divider at its terminal count while the rise is held
        cnt_d = (!sck_q && hold) ? cnt_q : '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      if (rise_ev) sck_d = 1'b1;
      if (fall_ev) sck_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck = sck_q;

endmodule

// File: rtl/dfr_cmd_tx.sv
module dfr_cmd_tx
  import dfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              shift,
  input  logic              release_io,
  output logic              sio_out,
  output logic              sio_oe
);

  logic [HDR_BITS-1:0] sh_q, sh_d;
  logic                oe_q, oe_d;

  always_comb begin
    sh_d = sh_q;
    oe_d = oe_q;
    if (load) begin
      sh_d = {DUAL_READ_OP, load_addr, 8'h00};
      oe_d = 1'b1;
    end else begin
      if (shift)      sh_d = {sh_q[HDR_BITS-2:0], 1'b0};
      if (release_io) oe_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      oe_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
      oe_q <= oe_d;
    end
  end

  assign sio_out = sh_q[HDR_BITS-1];
  assign sio_oe  = oe_q;

endmodule

// File: rtl/dfr_rx_pack.sv
module dfr_rx_pack
  import dfr_pkg::*;
#(
  parameter int ARRAY_BITS = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              sample,
  input  logic              so_in,
  input  logic              sio_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic [ADDR_W-1:0] out_addr,
  output logic              byte_done,
  output logic              at_byte_start
);

  logic [1:0]            pair_q, pair_d;
  logic [5:0]            acc_q, acc_d;
  logic [ARRAY_BITS-1:0] cur_q, cur_d;
  logic                  vld_q, vld_d;
  logic [7:0]            dat_q, dat_d;
  logic [ADDR_W-1:0]     adr_q, adr_d;

  assign byte_done     = sample && (pair_q == 2'(PAIRS_PER_B - 1));
  assign at_byte_start = (pair_q == 2'd0);

  always_comb begin
    pair_d = pair_q;
    acc_d  = acc_q;
    cur_d  = cur_q;
    dat_d  = dat_q;
    adr_d  = adr_q;
    vld_d  = vld_q && !out_ready;
    if (start) begin
      pair_d = 2'd0;
      cur_d  = start_addr[ARRAY_BITS-1:0];
    end else if (sample) begin
      pair_d = pair_q + 2'd1;
      acc_d  = {acc_q[3:0], so_in, sio_in};
      if (byte_done) begin
        dat_d = {acc_q, so_in, sio_in};
        adr_d = ADDR_W'(cur_q);
        vld_d = 1'b1;
        cur_d = cur_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_q <= 2'd0;
      acc_q  <= '0;
      cur_q  <= '0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
      adr_q  <= '0;
    end else begin
      pair_q <= pair_d;
      acc_q  <= acc_d;
      cur_q  <= cur_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
      adr_q  <= adr_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;
  assign out_addr  = adr_q;

endmodule

// File: rtl/dual_flash_reader.sv
module dual_flash_reader
  import dfr_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int CNT_W      = 16,
  parameter int ARRAY_BITS = 21,
  parameter int CS_GAP     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [23:0]       req_addr,
  input  logic [CNT_W-1:0]  req_count,
  output logic              done,
  output logic              cs_n,
  output logic              sck,
  output logic              sio_out,
  output logic              sio_oe,
  input  logic              sio_in,
  input  logic              so_in,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [23:0]       out_addr
);

  localparam int GAP_W = (CS_GAP > 2) ? $clog2(CS_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_LOAD = GAP_W'((CS_GAP > 1) ? CS_GAP - 1 : 0);
  localparam logic [5:0] EDGE_DUMMY = 6'(DUMMY_FIRST);
  localparam logic [5:0] EDGE_HDR   = 6'(HDR_BITS);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dfr_state_e       st_q, st_d;
  logic [5:0]       edge_q, edge_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic             last_q, last_d;
  logic             csn_q, csn_d;
  logic             done_q, done_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  logic accept, run, hold, rise_ev, fall_ev, shift, release_io, sample;
  logic byte_done, at_byte_start, close_ev;

  assign accept     = (st_q == ST_IDLE) && req_valid;
  assign run        = (st_q == ST_CMD) || (st_q == ST_DATA);
  assign hold       = (st_q == ST_DATA) && at_byte_start && out_valid && !out_ready;
  assign shift      = (st_q == ST_CMD) && fall_ev;
  assign release_io = shift && (edge_q == EDGE_DUMMY);
  assign sample     = (st_q == ST_DATA) && rise_ev;
  assign close_ev   = (st_q == ST_DATA) && fall_ev && last_q;

  dfr_sck_gen #(.HALF_DIV(HALF_DIV)) u_sck (
    .clk     (clk),
    .rst_n   (rst_sync),
    .run     (run),
    .hold    (hold),
    .sck     (sck),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  dfr_cmd_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_sync),
    .load       (accept),
    .load_addr  (req_addr),
    .shift      (shift),
    .release_io (release_io),
    .sio_out    (sio_out),
    .sio_oe     (sio_oe)
  );

  dfr_rx_pack #(.ARRAY_BITS(ARRAY_BITS)) u_rx (
    .clk           (clk),
    .rst_n         (rst_sync),
    .start         (accept),
    .start_addr    (req_addr),
    .sample        (sample),
    .so_in         (so_in),
    .sio_in        (sio_in),
    .out_ready     (out_ready),
    .out_valid     (out_valid),
    .out_data      (out_data),
    .out_addr      (out_addr),
    .byte_done     (byte_done),
    .at_byte_start (at_byte_start)
  );

  always_comb begin
    st_d   = st_q;
    edge_d = edge_q;
    left_d = left_q;
    last_d = last_q;
    csn_d  = csn_q;
    done_d = 1'b0;
    gap_d  = gap_q;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_CMD;
          edge_d = '0;
          left_d = req_count;
          last_d = 1'b0;
          csn_d  = 1'b0;
        end
      end
      ST_CMD: begin
        if (rise_ev) edge_d = edge_q + 6'd1;
        if (fall_ev && (edge_q == EDGE_HDR)) st_d = ST_DATA;
      end
      ST_DATA: begin
        if (byte_done) begin
          left_d = left_q - 1'b1;
          if (left_q == CNT_W'(1)) last_d = 1'b1;
        end
        if (close_ev) begin
          st_d   = ST_GAP;
          csn_d  = 1'b1;
          done_d = 1'b1;
          gap_d  = GAP_LOAD;
        end
      end
      ST_GAP: begin
        if (gap_q == '0) st_d = ST_IDLE;
        else             gap_d = gap_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      left_q <= '0;
      last_q <= 1'b0;
      csn_q  <= 1'b1;
      done_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      left_q <= left_d;
      last_q <= last_d;
      csn_q  <= csn_d;
      done_q <= done_d;
      gap_q  <= gap_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign cs_n      = csn_q;
  assign done      = done_q;

endmodule

// File: rtl/dfr_checker.sv
module dfr_checker #(
  parameter int ARRAY_BITS = 21
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic        cs_n,
  input logic        sck,
  input logic        sio_out,
  input logic        sio_oe,
  input logic        out_valid,
  input logic        out_ready,
  input logic [7:0]  out_data,
  input logic [23:0] out_addr
);

  logic       sck_prev;
  logic [6:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      rises    <= '0;
    end else begin
      sck_prev <= sck;
      if (cs_n)                rises <= '0;
      else if (sck && !sck_prev && rises != 7'h7F) rises <= rises + 7'd1;
    end
  end

  // R1: command line moves only on falling serial clock edges
  assert_cmd_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && sio_oe && !$stable(sio_out)) |-> (!sck && $past(sck)));

  // R3: line driven during command and address, released from the first dummy clock
  assert_io_driven_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && !sck_prev && rises < 7'd32) |-> sio_oe);
  assert_io_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sck && !sck_prev && rises >= 7'd32) |-> !sio_oe);

  // R6: reported address lies inside the array
  assert_addr_in_array_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_addr >> ARRAY_BITS) == 24'd0));

  // R8: a pending byte holds still
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr)));

  // R9: clock parked while deselected, single-cycle completion pulse
  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cs_n && !sck));

  // R10: chip select high for two cycles or more
  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);

endmodule

bind dual_flash_reader dfr_checker #(.ARRAY_BITS(ARRAY_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .done      (done),
  .cs_n      (cs_n),
  .sck       (sck),
  .sio_out   (sio_out),
  .sio_oe    (sio_oe),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_addr  (out_addr)
);

// File: tb/sim_dual_flash_reader.sv
`timescale 1ns/1ps
module sim_dual_flash_reader;

  localparam int HALF_DIV   = 2;
  localparam int CNT_W      = 16;
  localparam int ARRAY_BITS = 21;
  localparam int CS_GAP     = 2;
  localparam real CLK_NS    = 4.0;
  localparam logic [23:0] AMASK = 24'((64'd1 << ARRAY_BITS) - 1);

  logic             clk, rst_n;
  logic             req_valid, req_ready;
  logic [23:0]      req_addr;
  logic [CNT_W-1:0] req_count;
  logic             done, cs_n, sck, sio_out, sio_oe, sio_in, so_in;
  logic             out_valid, out_ready;
  logic [7:0]       out_data;
  logic [23:0]      out_addr;
  logic             dev_so, dev_sio;

  int n_tests = 0;
  int n_fail  = 0;

  dual_flash_reader #(.HALF_DIV(HALF_DIV), .CNT_W(CNT_W), .ARRAY_BITS(ARRAY_BITS), .CS_GAP(CS_GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count), .done(done), .cs_n(cs_n),
    .sck(sck), .sio_out(sio_out), .sio_oe(sio_oe), .sio_in(sio_in), .so_in(so_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_addr(out_addr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign so_in  = dev_so;
  assign sio_in = sio_oe ? 1'b0 : dev_sio;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [23:0] m;
    m = a & AMASK;
    return (m[7:0] * 8'd37) ^ m[15:8] ^ m[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  int          dev_rises;
  logic [39:0] dev_hdr;
  realtime     last_rise;
  bit          have_rise;
  bit          cont_mode;
  int          oe_viol, spacing_viol;

  always @(posedge sck) begin
    if (!cs_n) begin
      if (dev_rises < 40) dev_hdr = {dev_hdr[38:0], sio_out};
      if ((dev_rises < 32 && !sio_oe) || (dev_rises >= 32 && sio_oe)) oe_viol++;
      if (have_rise && cont_mode && ($realtime - last_rise != 2.0 * HALF_DIV * CLK_NS))
        spacing_viol++;
      last_rise = $realtime;
      have_rise = 1'b1;
      dev_rises++;
    end
  end

  always @(negedge sck) begin
    if (!cs_n && dev_rises >= 40) begin
      int p, sh;
      logic [23:0] a;
      logic [7:0]  b;
      p  = dev_rises - 40;
      a  = (dev_hdr[31:8] + 24'(p / 4)) & AMASK;
      b  = mem_byte(a);
      sh = 6 - 2 * (p % 4);
      dev_so  = b[sh+1];
      dev_sio = b[sh];
    end
  end

  // ---------------- consumer and port monitors ----------------
  bit          mon_on;
  int          ready_mode;
  logic [23:0] exp_addr;
  int          rx_bytes, done_seen, stall_run, hi_run;
  bit          prev_done, prev_cs_n, seen_txn;

  always @(negedge clk) begin
    if (mon_on) begin
      case (ready_mode)
        0:       out_ready = 1'b1;
        1:       out_ready = ($urandom % 4) != 0;
        default: out_ready = ($urandom % 16) == 0;
      endcase
      if (out_valid && out_ready) begin
        chk("R5", "byte address", out_addr, exp_addr);
        chk("R4", "byte data", out_data, mem_byte(exp_addr));
        exp_addr = (exp_addr + 24'd1) & AMASK;
        rx_bytes++;
      end
      if (out_valid && !out_ready) stall_run++;
      else stall_run = 0;
      if (stall_run == 10 * HALF_DIV + 6) chk("R8", "sck parked during stall", sck, 0);
      if (done) begin
        done_seen++;
        chk("R9", "cs_n at done", cs_n, 1);
        chk("R9", "sck at done", sck, 0);
      end
      if (done && prev_done) chk("R9", "done pulse width", 2, 1);
      prev_done = done;
      if (cs_n) hi_run++;
      else begin
        if (prev_cs_n && seen_txn) chk("R10", "cs_n high cycles >= 2", hi_run >= 2, 1);
        seen_txn = 1'b1;
        hi_run = 0;
      end
      prev_cs_n = cs_n;
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- transaction driver ----------------
  task automatic run_txn(input logic [23:0] addr, input int count, input int mode);
    int waitc;
    while (!req_ready) @(negedge clk);
    ready_mode   = mode;
    cont_mode    = (mode == 0);
    dev_rises    = 0;
    have_rise    = 1'b0;
    oe_viol      = 0;
    spacing_viol = 0;
    exp_addr     = addr & AMASK;
    rx_bytes     = 0;
    done_seen    = 0;
    req_valid    = 1'b1;
    req_addr     = addr;
    req_count    = CNT_W'(count);
    @(negedge clk);
    req_valid    = 1'b0;
    while (!(done_seen > 0 && rx_bytes == count)) @(negedge clk);
    chk("R1", "command byte", dev_hdr[39:32], 8'h3B);
    chk("R2", "address on wire", dev_hdr[31:8], addr);
    chk("R3", "sio_oe schedule violations", oe_viol, 0);
    chk("R7", "sck rising edges", dev_rises, 40 + 4 * count);
    if (cont_mode) chk("R7", "sck spacing violations", spacing_viol, 0);
    chk("R5", "bytes delivered", rx_bytes, count);
    chk("R9", "done pulses", done_seen, 1);
    waitc = 0;
    while (!req_ready && waitc < CS_GAP + 4) begin
      @(negedge clk);
      waitc++;
    end
    chk("R9", "idle return within gap", (waitc <= CS_GAP + 1), 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_addr  = '0;
    req_count = '0;
    out_ready = 1'b0;
    dev_so    = 1'b0;
    dev_sio   = 1'b0;
    dev_hdr   = '0;
    mon_on    = 1'b0;
    ready_mode = 0;
    repeat (4) @(negedge clk);
    chk("R11", "cs_n in reset", cs_n, 1);
    chk("R11", "sck in reset", sck, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "cs_n after reset", cs_n, 1);
    chk("R11", "sck after reset", sck, 0);
    chk("R11", "sio_oe after reset", sio_oe, 0);
    chk("R11", "out_valid after reset", out_valid, 0);
    chk("R11", "done after reset", done, 0);
    chk("R11", "req_ready after reset", req_ready, 1);
    prev_cs_n = 1'b1;
    mon_on = 1'b1;

    // directed: single byte, continuous consumer
    run_txn(24'h000000, 1, 0);
    // directed: across the top of the array (R6)
    run_txn(24'h1FFFFD, 6, 0);
    chk("R6", "address after wrap", exp_addr, 24'h000003);
    // directed: slow consumer forces clock parking (R8)
    run_txn(24'h123456, 5, 2);
    // directed: upper address bits beyond the array, wrap with stalls
    run_txn(24'hFFFFFE, 4, 1);
    chk("R6", "masked wrap address", exp_addr, 24'h000002);

    for (int i = 0; i < 14; i++) begin
      logic [23:0] a;
      int c, m;
      if (($urandom % 4) == 0) a = AMASK - 24'($urandom % 8);
      else                     a = 24'($urandom);
      c = 1 + ($urandom % 12);
      m = $urandom % 3;
      run_txn(a, c, m);
    end

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule